// File: doc/BRIEF.md
# Incremental Partial-Square Squarer

This block squares an unsigned W-bit fixed-point fraction without a general multiplier array. It relies on the symmetry of squaring. A bit multiplied by itself is just that bit. The two mirrored cross products of any pair of distinct bits sum to one product at double weight. The reduced array therefore holds roughly half the terms of a full multiplier.

The square is built one operand bit at a time, starting from the least significant bit. Each step adds the new bit's self term and its doubled cross terms against the bits already taken in. The running value after each step is exactly the square of the operand truncated to the bits processed so far. The block exposes every one of these intermediate squares next to the full result. A datapath that also needs the square of a shortened operand gets it from this block at no extra cost. The block is purely combinational and has no clock or reset.

Top module: `psq_squarer`

## Requirements
- R1: For every W-bit unsigned `op_i`, `square_o` equals `op_i * op_i` taken as a 2W-bit value.
- R2: Slot j of `partial_o` (bits `[j*2W +: 2W]`, j = 0..W-1) equals the square of `op_i[j:0]`, zero-extended to 2W bits.
- R3: Slot 0 equals `op_i[0]` in bit 0, and its bit 1 and all higher bits are always 0.
- R4: The last slot (j = W-1) equals `square_o`.
- R5: When exactly one bit i of `op_i` is set, `square_o` has exactly one bit set, at position 2i.
- R6: When `op_i[W-1]` is 0, the top two bits of `square_o` are 0. Bit 2W-1 can only be set as a carry out of the position below it.
- R7: With `op_i` equal to 0, `square_o` and every slot of `partial_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | W | Unsigned operand (fraction bits, LSB first in weight) |
| square_o | output | 2*W | Full square of `op_i` |
| partial_o | output | W*2*W | W slots of 2W bits each. Slot j holds the square of `op_i[j:0]` |

## Verification
Every operand is driven on a 6-bit instance and on an 8-bit instance. The full square and every intermediate slot are compared against squares that the bench computes itself. Several errors only show up on particular operands:
- A doubled cross term placed at the wrong weight corrupts only operands that have two or more bits set.
- A self term kept as a product at the wrong weight disturbs single-bit operands.
- A chain that drops its carry into the top bit fails only when the most significant bits are set.

The single-bit, zero and top-bit cases are also checked on their own so that each of these faults is tied to its requirement.

// File: rtl/psq_pkg.sv
// Package: shared helpers for the partial-square squarer.
// Assumes the operand width is at least 2.
package psq_pkg;

    // Lowest bit index of partial slot j inside the flattened slot bus.
    function automatic int slot_lo(input int w, input int j);
        return j * 2 * w;
    endfunction

endpackage

// File: rtl/psq_seed.sv
// Module: psq_seed
// Forms the first running square from operand bit 0 alone.
// The self term of bit 0 is the bit itself, and bit 1 is always zero.
module psq_seed #(
    parameter int W = 6
) (
    input  logic [W-1:0]   op_i,
    output logic [2*W-1:0] sq_o
);
    localparam int DW = 2 * W;

    // Place bit 0 at weight 1; every other position is zero.
    always_comb begin
        sq_o    = '0;
        sq_o[0] = op_i[0];
    end
endmodule

// File: rtl/psq_stage.sv
// Module: psq_stage
// Adds operand bit S to the square of op[S-1:0]. The result is the square of op[S:0].
// The terms added are the self term x_S at weight 2S and the folded cross
// terms x_S*op[S-1:0] at weight S+1.
// Assumes 1 <= S <= W-1.
module psq_stage #(
    parameter int W = 6,
    parameter int S = 1
) (
    input  logic [W-1:0]   op_i,
    input  logic [2*W-1:0] prev_i,
    output logic [2*W-1:0] next_o
);
    localparam int DW = 2 * W;

    logic [DW-1:0] cross_row;
    logic [DW-1:0] self_row;

    // Build the folded cross row and the self term, then accumulate.
    always_comb begin
        cross_row = '0;
        if (op_i[S]) begin
            cross_row = DW'(op_i[S-1:0]) << (S + 1);
        end
        self_row = DW'(op_i[S]) << (2 * S);
        next_o   = prev_i + cross_row + self_row;
    end
endmodule

// File: rtl/psq_squarer.sv
// Module: psq_squarer (top)
// Unsigned squarer built as a chain of W accumulation steps, least significant bit first.
// Each step's running square is exported as a slot of partial_o. The last step is the full square.
// Purely combinational. Assumes W >= 2.
module psq_squarer #(
    parameter int W = 6
) (
    input  logic [W-1:0]     op_i,
    output logic [2*W-1:0]   square_o,
    output logic [W*2*W-1:0] partial_o
);
    import psq_pkg::*;

    localparam int DW = 2 * W;

    logic [DW-1:0] run_sq [W];

    psq_seed #(.W(W)) u_seed (
        .op_i (op_i),
        .sq_o (run_sq[0])
    );

    // One accumulation step per operand bit above bit 0.
    for (genvar s = 1; s < W; s++) begin : g_step
        psq_stage #(.W(W), .S(s)) u_step (
            .op_i   (op_i),
            .prev_i (run_sq[s-1]),
            .next_o (run_sq[s])
        );
    end

    // Export every running square as a slot.
    for (genvar j = 0; j < W; j++) begin : g_slot
        assign partial_o[slot_lo(W, j) +: DW] = run_sq[j];
    end

    assign square_o = run_sq[W-1];
endmodule

// File: rtl/psq_checker.sv
// Module: psq_checker
// Attached to psq_squarer by bind. Checks the square and the slots against
// arithmetic squares. It uses immediate assertions because the block has no clock.
module psq_checker #(
    parameter int W = 6
) (
    input logic [W-1:0]     op_i,
    input logic [2*W-1:0]   square_o,
    input logic [W*2*W-1:0] partial_o
);
    localparam int DW = 2 * W;

    logic          slot_bad;
    logic [DW-1:0] trunc;

    // Flag any slot that differs from the square of its truncated operand.
    always_comb begin
        slot_bad = 1'b0;
        for (int j = 0; j < W; j++) begin
            trunc = DW'(op_i & W'((1 << (j + 1)) - 1));
            if (partial_o[j*DW +: DW] != DW'(trunc * trunc)) slot_bad = 1'b1;
        end
    end

    // Immediate checks, skipped while the operand is unknown.
    always_comb begin
        if (!$isunknown(op_i)) begin
            // R1
            square_match_chk: assert (square_o == DW'(DW'(op_i) * DW'(op_i)));
            // R2
            slot_match_chk: assert (!slot_bad);
            // R3
            slot0_bit1_chk: assert (partial_o[DW-1:1] == '0);
            // R4
            last_slot_chk: assert (partial_o[(W-1)*DW +: DW] == square_o);
            // R5
            one_hot_chk: assert (!$onehot(op_i) || $countones(square_o) == 1);
            // R6
            top_clear_chk: assert (op_i[W-1] || square_o[DW-1:DW-2] == 2'b00);
        end
    end
endmodule

bind psq_squarer psq_checker #(.W(W)) u_psq_chk (
    .op_i      (op_i),
    .square_o  (square_o),
    .partial_o (partial_o)
);

// File: tb/psq_squarer_bench.sv
// Directed bench: drives a 6-bit and an 8-bit squarer together and checks both against computed squares.
module psq_squarer_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [5:0]   op6;
    logic [11:0]  sq6;
    logic [71:0]  pt6;
    logic [7:0]   op8;
    logic [15:0]  sq8;
    logic [127:0] pt8;

    int runs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    psq_squarer #(.W(6)) u_psq_squarer (.op_i(op6), .square_o(sq6), .partial_o(pt6));
    psq_squarer #(.W(8)) u_psq_squarer8 (.op_i(op8), .square_o(sq8), .partial_o(pt8));

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input int v);
        @(posedge clk);
        op6 = 6'(v);
        op8 = 8'(v);
        @(negedge clk);
    endtask

    // R7: zero operand gives all-zero outputs
    task automatic t_zero();
        apply(0);
        chk("R7 sq6", 128'(sq6), 0);
        chk("R7 pt6", 128'(pt6), 0);
        chk("R7 sq8", 128'(sq8), 0);
        chk("R7 pt8", pt8, 0);
    endtask

    // R1, R2, R4: every operand, full square and every slot
    task automatic t_sweep();
        for (int v = 0; v < 256; v++) begin
            apply(v);
            chk("R1 w8", 128'(sq8), 128'(v * v));
            chk("R4 w8", 128'(pt8[7*16 +: 16]), 128'(sq8));
            for (int j = 0; j < 8; j++) begin
                int t = v & ((1 << (j + 1)) - 1);
                chk("R2 w8", 128'(pt8[j*16 +: 16]), 128'(t * t));
            end
            if (v < 64) begin
                chk("R1 w6", 128'(sq6), 128'(v * v));
                chk("R4 w6", 128'(pt6[5*12 +: 12]), 128'(sq6));
                for (int j = 0; j < 6; j++) begin
                    int t = v & ((1 << (j + 1)) - 1);
                    chk("R2 w6", 128'(pt6[j*12 +: 12]), 128'(t * t));
                end
            end
        end
    endtask

    // R3: slot 0 holds only bit 0 of the operand
    task automatic t_slot0();
        for (int v = 0; v < 4; v++) begin
            apply(v);
            chk("R3 w6", 128'(pt6[11:0]), 128'(v & 1));
            chk("R3 w8", 128'(pt8[15:0]), 128'(v & 1));
        end
    endtask

    // R5: a single set bit i squares to a single bit at 2i
    task automatic t_onehot();
        for (int i = 0; i < 8; i++) begin
            apply(1 << i);
            chk("R5 w8", 128'(sq8), 128'(1) << (2 * i));
            if (i < 6) chk("R5 w6", 128'(sq6), 128'(1) << (2 * i));
        end
    endtask

    // R6: top bits clear without the operand MSB; the all-ones operand sets the carry bit
    task automatic t_top();
        apply(31);
        chk("R6 w6 msb0", 128'(sq6[11:10]), 0);
        apply(127);
        chk("R6 w8 msb0", 128'(sq8[15:14]), 0);
        apply(255);
        chk("R6 w8 ones", 128'(sq8), 128'(16'hFE01));
        chk("R6 w6 ones", 128'(sq6), 128'(12'hF81));
    endtask

    initial begin
        op6 = '0;
        op8 = '0;
        t_zero();
        t_slot0();
        t_onehot();
        t_top();
        t_sweep();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            runs++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule